// File: doc/BRIEF.md
# Two-Word Instruction Sequencer

This block runs a small 16-bit processor core whose instructions take two words. The first word carries the opcode fields. The second word carries an address or jump target. Both words come from the same single-port memory that holds data. The sequencer fetches the opcode word, then the address word, and then executes.

In the execute step, one of eight source locations is read and fed to the ALU as its y operand. Register A is always the x operand. The ALU result goes to one of the same eight locations, so every load, store and move is an ALU pass. The ALU flags then decide whether the program counter takes the jump target or moves on to the next instruction pair. When both the source and the destination are in memory, the write is moved into an extra cycle, so only one memory access happens per cycle.

Top module: `twoword_core`

## Requirements
- R1: While reset is high, and just after it, PC, A, D and X are 0, the stack register is 0x7FFF, the carry latch is 0 and no memory write is driven.
- R2: Each instruction first reads the opcode word at address PC, then the second word at PC+1, and then executes. The second word is always fetched. Registers do not change during either fetch cycle. An instruction whose source or destination is not memory completes in 3 clock cycles.
- R3: The opcode word is laid out as follows. Bits 15:13 are the source location and bits 12:10 the destination location. Bits 9:4 are the ALU controls, in order from bit 9 down: zero-x, invert-x, zero-y, invert-y, add-not-and, invert-out. Bit 3 is use-carry and bits 2:0 are the jump condition.
- R4: Location codes are: 000 A, 001 memory[A], 010 stack register, 011 memory[stack register], 100 X, 101 memory[X], 110 D, 111 memory[second word]. Odd codes are memory locations.
- R5: The ALU takes x = A and y = the source location. It optionally zeroes and then inverts each operand. It then either ANDs them or adds them with a carry-in, and optionally inverts the result. The carry-in is the carry latch when use-carry is 1 and 0 otherwise.
- R6: Every executed instruction loads the carry latch. With add selected, it gets the adder carry-out taken before output inversion. With AND selected, it gets 0.
- R7: When both the source and the destination are memory locations, the read happens in the execute cycle and the write in the following cycle. The instruction then takes 4 clock cycles.
- R8: Jump codes are: 000 never, 001 result zero, 010 result negative, 011 carry-out set, 100 always, 101 result non-zero, 110 result positive (not zero and not negative), 111 carry-out clear. The tests use this instruction's own result. A taken jump loads PC with the second word. Otherwise PC advances by 2.
- R9: Exactly one destination is written per instruction. A memory destination receives the ALU result at the address that its code selects, and no other memory word changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 16 | Read data from memory, combinational from mem_addr |
| mem_addr | output | 16 | Word address for the current access |
| mem_wdata | output | 16 | Write data |
| mem_we | output | 1 | Memory write strobe, taken at the rising edge |
| a_q | output | 16 | Register A |
| d_q | output | 16 | Register D |
| x_q | output | 16 | Register X |
| sp_q | output | 16 | Stack register |
| pc_q | output | 16 | Program counter |
| carry_q | output | 1 | Carry latch |

## Verification
Register results of an instruction appear after the third rising edge following its first fetch cycle. When both the source and the destination are memory locations, they appear after the fourth edge. The bench works this count out from bits 13 and 10 of each opcode word it issues. It waits that many edges and samples all registers on the next falling edge, so each vector is compared exactly when its instruction retires. Memory results are read from the bench's own memory model after the program ends. The state of the fetch phase is checked on the falling edge after the last instruction retires.

// File: rtl/seq_pkg.sv
package seq_pkg;
    localparam int WORD = 16;

    typedef enum logic [2:0] {
        LOC_A   = 3'b000,
        LOC_MA  = 3'b001,
        LOC_SP  = 3'b010,
        LOC_MSP = 3'b011,
        LOC_X   = 3'b100,
        LOC_MX  = 3'b101,
        LOC_D   = 3'b110,
        LOC_MI  = 3'b111
    } loc_e;

    typedef enum logic [2:0] {
        J_NEVER  = 3'b000,
        J_ZERO   = 3'b001,
        J_NEG    = 3'b010,
        J_CARRY  = 3'b011,
        J_ALWAYS = 3'b100,
        J_NZERO  = 3'b101,
        J_POS    = 3'b110,
        J_NCARRY = 3'b111
    } jcond_e;

    typedef struct packed {
        logic zx;
        logic nx;
        logic zy;
        logic ny;
        logic f;
        logic no;
    } alu_ctl_t;

    typedef struct packed {
        loc_e     src;
        loc_e     dst;
        alu_ctl_t alu;
        logic     uc;
        jcond_e   jc;
    } instr_t;

    typedef struct packed {
        logic a;
        logic d;
        logic x;
        logic sp;
    } reg_we_t;

    typedef enum logic [1:0] {
        ST_FETCH0 = 2'd0,
        ST_FETCH1 = 2'd1,
        ST_EXEC   = 2'd2,
        ST_WRMEM  = 2'd3
    } state_e;

    function automatic logic loc_is_mem(loc_e l);
        return l[0];
    endfunction

    function automatic logic [WORD-1:0] loc_addr(loc_e l, logic [WORD-1:0] a,
                                                 logic [WORD-1:0] sp, logic [WORD-1:0] x,
                                                 logic [WORD-1:0] imm);
        case (l)
            LOC_MA:  return a;
            LOC_MSP: return sp;
            LOC_MX:  return x;
            LOC_MI:  return imm;
            default: return '0;
        endcase
    endfunction
endpackage

// File: rtl/seq_alu.sv
module seq_alu
    import seq_pkg::*;
(
    input  logic [WORD-1:0] x,
    input  logic [WORD-1:0] y,
    input  alu_ctl_t        ctl,
    input  logic            cin,
    output logic [WORD-1:0] res,
    output logic            cout
);
    logic [WORD-1:0] xz, xn, yz, yn, fo;
    logic [WORD:0]   sum;

    always_comb begin
        xz   = ctl.zx ? '0 : x;
        xn   = ctl.nx ? ~xz : xz;
        yz   = ctl.zy ? '0 : y;
        yn   = ctl.ny ? ~yz : yz;
        sum  = {1'b0, xn} + {1'b0, yn} + {{WORD{1'b0}}, cin};
        fo   = ctl.f ? sum[WORD-1:0] : (xn & yn);
        res  = ctl.no ? ~fo : fo;
        cout = ctl.f & sum[WORD];
    end
endmodule

// File: rtl/seq_decode.sv
module seq_decode
    import seq_pkg::*;
(
    input  instr_t          ins,
    input  logic [WORD-1:0] imm,
    input  logic [WORD-1:0] a,
    input  logic [WORD-1:0] d,
    input  logic [WORD-1:0] x,
    input  logic [WORD-1:0] sp,
    input  logic [WORD-1:0] rdata,
    output logic [WORD-1:0] y_val,
    output logic [WORD-1:0] rd_addr,
    output logic [WORD-1:0] wr_addr,
    output logic            rd_mem,
    output logic            wr_mem,
    output reg_we_t         reg_we
);
    always_comb begin
        rd_mem  = loc_is_mem(ins.src);
        wr_mem  = loc_is_mem(ins.dst);
        rd_addr = loc_addr(ins.src, a, sp, x, imm);
        wr_addr = loc_addr(ins.dst, a, sp, x, imm);
        case (ins.src)
            LOC_A:   y_val = a;
            LOC_SP:  y_val = sp;
            LOC_X:   y_val = x;
            LOC_D:   y_val = d;
            default: y_val = rdata;
        endcase
        reg_we    = '0;
        reg_we.a  = (ins.dst == LOC_A);
        reg_we.d  = (ins.dst == LOC_D);
        reg_we.x  = (ins.dst == LOC_X);
        reg_we.sp = (ins.dst == LOC_SP);
    end
endmodule

// File: rtl/seq_branch.sv
module seq_branch
    import seq_pkg::*;
(
    input  jcond_e          jc,
    input  logic [WORD-1:0] res,
    input  logic            cout,
    output logic            take
);
    logic zero, neg;

    always_comb begin
        zero = (res == '0);
        neg  = res[WORD-1];
        case (jc)
            J_ZERO:   take = zero;
            J_NEG:    take = neg;
            J_CARRY:  take = cout;
            J_ALWAYS: take = 1'b1;
            J_NZERO:  take = !zero;
            J_POS:    take = !zero && !neg;
            J_NCARRY: take = !cout;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/twoword_core.sv
module twoword_core
    import seq_pkg::*;
#(
    parameter logic [WORD-1:0] SP_INIT = 16'h7FFF,
    parameter int              PC_STEP = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [WORD-1:0] mem_rdata,
    output logic [WORD-1:0] mem_addr,
    output logic [WORD-1:0] mem_wdata,
    output logic            mem_we,
    output logic [WORD-1:0] a_q,
    output logic [WORD-1:0] d_q,
    output logic [WORD-1:0] x_q,
    output logic [WORD-1:0] sp_q,
    output logic [WORD-1:0] pc_q,
    output logic            carry_q
);
    localparam logic [WORD-1:0] STEP = WORD'(PC_STEP);

    state_e          state_q;
    logic [WORD-1:0] ins0_q, ins1_q, res_q;
    instr_t          ins;
    logic [WORD-1:0] y_val, rd_addr, wr_addr, alu_res;
    logic            rd_mem, wr_mem, alu_cout, take;
    reg_we_t         reg_we;

    assign ins = instr_t'(ins0_q);

    seq_decode u_dec (
        .ins(ins), .imm(ins1_q), .a(a_q), .d(d_q), .x(x_q), .sp(sp_q),
        .rdata(mem_rdata), .y_val(y_val), .rd_addr(rd_addr), .wr_addr(wr_addr),
        .rd_mem(rd_mem), .wr_mem(wr_mem), .reg_we(reg_we)
    );

    seq_alu u_alu (
        .x(a_q), .y(y_val), .ctl(ins.alu), .cin(ins.uc & carry_q),
        .res(alu_res), .cout(alu_cout)
    );

    seq_branch u_br (
        .jc(ins.jc), .res(alu_res), .cout(alu_cout), .take(take)
    );

    always_comb begin
        case (state_q)
            ST_FETCH0: mem_addr = pc_q;
            ST_FETCH1: mem_addr = pc_q + WORD'(1);
            ST_EXEC:   mem_addr = rd_mem ? rd_addr : wr_addr;
            default:   mem_addr = wr_addr;
        endcase
        mem_we    = (state_q == ST_WRMEM) || (state_q == ST_EXEC && wr_mem && !rd_mem);
        mem_wdata = (state_q == ST_WRMEM) ? res_q : alu_res;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH0;
            ins0_q  <= '0;
            ins1_q  <= '0;
            res_q   <= '0;
            a_q     <= '0;
            d_q     <= '0;
            x_q     <= '0;
            sp_q    <= SP_INIT;
            pc_q    <= '0;
            carry_q <= 1'b0;
        end else begin
            case (state_q)
                ST_FETCH0: begin
                    ins0_q  <= mem_rdata;
                    state_q <= ST_FETCH1;
                end
                ST_FETCH1: begin
                    ins1_q  <= mem_rdata;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (reg_we.a)  a_q  <= alu_res;
                    if (reg_we.d)  d_q  <= alu_res;
                    if (reg_we.x)  x_q  <= alu_res;
                    if (reg_we.sp) sp_q <= alu_res;
                    carry_q <= alu_cout;
                    res_q   <= alu_res;
                    pc_q    <= take ? ins1_q : pc_q + STEP;
                    state_q <= (rd_mem && wr_mem) ? ST_WRMEM : ST_FETCH0;
                end
                default: state_q <= ST_FETCH0;
            endcase
        end
    end

    // R1
    reset_init_chk: assert property (@(posedge clk)
        rst |=> (pc_q == '0 && sp_q == SP_INIT && a_q == '0 && !carry_q && !mem_we));

    // R2
    fetch_order_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FETCH0 |=> state_q == ST_FETCH1);

    // R2
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_FETCH0 |=> ($stable(a_q) && $stable(pc_q) && $stable(carry_q) && !mem_we));

    // R7
    split_write_chk: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_WRMEM |-> ($past(state_q) == ST_EXEC && mem_we));

    // R8
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && ins.jc == J_NEVER) |=> pc_q == $past(pc_q) + STEP);
endmodule

// File: tb/twoword_core_bench.sv
module twoword_core_bench;
    typedef struct packed {
        logic [15:0] i0;
        logic [15:0] i1;
        logic [15:0] a;
        logic [15:0] d;
        logic [15:0] x;
        logic [15:0] sp;
        logic [15:0] pc;
        logic        c;
        logic [15:0] tag;
    } vec_t;

    function automatic logic [15:0] enc(logic [2:0] r, logic [2:0] w, logic [5:0] f,
                                        logic u, logic [2:0] j);
        return {r, w, f, u, j};
    endfunction

    localparam logic [5:0] F_Y    = 6'b110000;
    localparam logic [5:0] F_ADD  = 6'b000010;
    localparam logic [5:0] F_SUB  = 6'b010011;
    localparam logic [5:0] F_NEG1 = 6'b111010;
    localparam logic [5:0] F_YP1  = 6'b110111;
    localparam logic [5:0] F_X    = 6'b001100;
    localparam int NV = 18;

    localparam vec_t VEC [NV] = '{
        '{enc(3'd7,3'd0,F_Y,1'b0,3'd0),   16'h0040, 16'h1234,16'h0000,16'h0000,16'h7FFF,16'h0002,1'b0,"R4"},
        '{enc(3'd7,3'd6,F_Y,1'b0,3'd0),   16'h0041, 16'h1234,16'h0005,16'h0000,16'h7FFF,16'h0004,1'b0,"R4"},
        '{enc(3'd6,3'd0,F_ADD,1'b0,3'd0), 16'h0000, 16'h1239,16'h0005,16'h0000,16'h7FFF,16'h0006,1'b0,"R5"},
        '{enc(3'd7,3'd4,F_Y,1'b0,3'd0),   16'h0042, 16'h1239,16'h0005,16'hFFFF,16'h7FFF,16'h0008,1'b0,"R4"},
        '{enc(3'd4,3'd0,F_ADD,1'b0,3'd0), 16'h0000, 16'h1238,16'h0005,16'hFFFF,16'h7FFF,16'h000A,1'b1,"R6"},
        '{enc(3'd6,3'd6,F_ADD,1'b1,3'd0), 16'h0000, 16'h1238,16'h123E,16'hFFFF,16'h7FFF,16'h000C,1'b0,"R5"},
        '{enc(3'd6,3'd7,F_Y,1'b0,3'd0),   16'h0050, 16'h1238,16'h123E,16'hFFFF,16'h7FFF,16'h000E,1'b0,"R9"},
        '{enc(3'd3,3'd7,F_Y,1'b0,3'd0),   16'h0051, 16'h1238,16'h123E,16'hFFFF,16'h7FFF,16'h0010,1'b0,"R7"},
        '{enc(3'd2,3'd4,F_Y,1'b0,3'd0),   16'h0000, 16'h1238,16'h123E,16'h7FFF,16'h7FFF,16'h0012,1'b0,"R4"},
        '{enc(3'd0,3'd5,F_Y,1'b0,3'd0),   16'h0000, 16'h1238,16'h123E,16'h7FFF,16'h7FFF,16'h0014,1'b0,"R9"},
        '{enc(3'd0,3'd6,F_SUB,1'b0,3'd1), 16'h0020, 16'h1238,16'h0000,16'h7FFF,16'h7FFF,16'h0020,1'b0,"R8"},
        '{enc(3'd6,3'd0,F_NEG1,1'b0,3'd2),16'h0030, 16'hFFFF,16'h0000,16'h7FFF,16'h7FFF,16'h0030,1'b0,"R8"},
        '{enc(3'd0,3'd0,F_YP1,1'b0,3'd5), 16'h0040, 16'h0000,16'h0000,16'h7FFF,16'h7FFF,16'h0032,1'b0,"R8"},
        '{enc(3'd4,3'd0,F_ADD,1'b0,3'd6), 16'h0036, 16'h7FFF,16'h0000,16'h7FFF,16'h7FFF,16'h0036,1'b0,"R8"},
        '{enc(3'd1,3'd5,F_YP1,1'b0,3'd4), 16'h003A, 16'h7FFF,16'h0000,16'h7FFF,16'h7FFF,16'h003A,1'b1,"R7"},
        '{enc(3'd4,3'd2,F_ADD,1'b0,3'd7), 16'h0044, 16'h7FFF,16'h0000,16'h7FFF,16'hFFFE,16'h0044,1'b0,"R8"},
        '{enc(3'd2,3'd6,F_ADD,1'b0,3'd3), 16'h0048, 16'h7FFF,16'h7FFD,16'h7FFF,16'hFFFE,16'h0048,1'b1,"R8"},
        '{enc(3'd6,3'd4,F_X,1'b0,3'd1),   16'h0000, 16'h7FFF,16'h7FFD,16'h7FFF,16'hFFFE,16'h004A,1'b0,"R6"}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_we;
    logic [15:0] a_q, d_q, x_q, sp_q, pc_q;
    logic        carry_q;
    logic [15:0] mem [256];
    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;

    twoword_core u_twoword_core (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .a_q(a_q), .d_q(d_q), .x_q(x_q),
        .sp_q(sp_q), .pc_q(pc_q), .carry_q(carry_q)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
        for (int k = 0; k < NV; k++) begin
            automatic int base = (k == 0) ? 0 : int'(VEC[k-1].pc);
            mem[base]     = VEC[k].i0;
            mem[base + 1] = VEC[k].i1;
        end
        mem[8'h40] = 16'h1234;
        mem[8'h41] = 16'h0005;
        mem[8'h42] = 16'hFFFF;
        mem[8'hFF] = 16'h0777;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", {a_q, d_q, x_q, sp_q, pc_q, 15'd0, carry_q},
                    {16'h0, 16'h0, 16'h0, 16'h7FFF, 16'h0, 15'd0, 1'b0});
        check("R1", {95'd0, mem_we}, 96'd0);
        rst = 1'b0;

        // R2 R3: 3 cycles per instruction, 4 when source and destination are memory (R7)
        for (int k = 0; k < NV; k++) begin
            automatic int n = (VEC[k].i0[13] && VEC[k].i0[10]) ? 4 : 3;
            automatic string t = $sformatf("R2/%s", VEC[k].tag);
            repeat (n) @(posedge clk);
            @(negedge clk);
            check(t, {a_q, d_q, x_q, sp_q, pc_q, 15'd0, carry_q},
                     {VEC[k].a, VEC[k].d, VEC[k].x, VEC[k].sp, VEC[k].pc, 15'd0, VEC[k].c});
        end

        // R9: single stores land at selected addresses
        check("R9", {80'd0, mem[8'h50]}, {80'd0, 16'h123E});
        // R7: memory-to-memory copy and read-modify-write
        check("R7", {80'd0, mem[8'h51]}, {80'd0, 16'h0777});
        check("R7", {80'd0, mem[8'hFF]}, {80'd0, 16'h1239});
        // R9: source data words untouched
        check("R9", {64'd0, mem[8'h40], mem[8'h42]}, {64'd0, 16'h1234, 16'hFFFF});
        // R2: next fetch phase addresses PC and writes nothing
        check("R2", {79'd0, mem_we, mem_addr}, {79'd0, 1'b0, 16'h004A});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule